// File: doc/BRIEF.md
# Multi-Width Transmit Byte Loader

This block sits between the software register write port of a serial flash controller and its byte-wide transmit FIFO. Software can choose among four write registers. Each one takes a 32-bit word and turns it into a different number of byte pushes, always starting from the least significant byte. This lets a command plus address, a lone opcode, or a short payload be queued with a single register write. Each accepted write is unrolled into single-byte pushes, one per clock. While those bytes drain into the FIFO, or while the FIFO is full, the write port holds off further writes.

The loader remembers which register was used last. Software may keep writing the same register at any time. Moving to a different register is legal only once the transmit FIFO has emptied. If a write breaks that rule, the loader discards it and raises a sticky error flag. Software clears the flag with a write-one-to-clear strobe.

Top module: `txWritePort`

## Requirements
- R1: A write to register index 0 pushes four bytes in this order: bits [7:0], [15:8], [23:16], [31:24].
- R2: A write to register index 1 pushes exactly one byte, bits [7:0].
- R3: A write to register index 2 pushes two bytes in this order: bits [7:0], then bits [15:8].
- R4: A write to register index 3 pushes three bytes in this order: bits [7:0], [15:8], [23:16].
- R5: At most one byte is pushed per clock. `pushValid` is never high while `fifoFull` is high. A push stalled by a full FIFO resumes in order once space opens.
- R6: `wrReady` is low while bytes from an earlier write are still waiting to be pushed, and also while `fifoFull` is high. A write is taken only in a cycle where both `wrValid` and `wrReady` are high.
- R7: A write to an index different from the last accepted index, taken while `fifoEmpty` is low, pushes no bytes. It also sets `errFlag` on the following clock.
- R8: A write to the same index as the last accepted one is accepted whether the FIFO is empty or not. A write to a different index is accepted when `fifoEmpty` is high.
- R9: `errFlag` stays high until `errClr` is pulsed. A cycle with `errClr` high and no write clears it on the next clock.
- R10: Bits above the bytes a register uses have no effect on the pushed bytes.
- R11: After reset, `errFlag` and `pushValid` are low and no index is remembered, so the first write to any register is accepted regardless of `fifoEmpty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Register write request |
| wrIdx | input | 2 | Register index (0..3) selecting the byte count |
| wrData | input | 32 | Write data word |
| wrReady | output | 1 | Loader can accept a write this cycle |
| errClr | input | 1 | Write-one-to-clear strobe for the error flag |
| errFlag | output | 1 | Sticky illegal-width-switch flag |
| pushValid | output | 1 | Byte push to the transmit FIFO |
| pushData | output | 8 | Byte being pushed |
| fifoFull | input | 1 | Transmit FIFO cannot take a byte |
| fifoEmpty | input | 1 | Transmit FIFO holds no bytes |

## Verification
The assertions assume that `fifoFull` and `fifoEmpty` come from a real FIFO. In particular, they assume the two flags are never high together, and that `fifoEmpty` already reflects the bytes this loader pushed on earlier clocks. The bench meets this by modelling an eight-entry FIFO whose flags are derived from one occupancy counter, updated on the same edge as each push and pop. It pops only when told to drain. The bench changes `wrValid`, `wrIdx` and `errClr` only on falling edges, so every write request stays stable across the edge that samples it.

// File: rtl/txw_pkg.sv
package txw_pkg;

  // strobes from the control half to the byte datapath
  typedef struct packed {
    logic load;   // capture a new word and its byte count
    logic shift;  // one byte leaves this clock
    logic drop;   // write discarded (illegal width switch)
  } txwStrobe_t;

  // byte count selected by a register index: index 0 carries a full word,
  // index k otherwise carries k bytes
  function automatic int unsigned bytesForIdx(input int unsigned idx,
                                              input int unsigned lanes);
    return (idx == 0) ? lanes : idx;
  endfunction

endpackage

// File: rtl/txwDatapath.sv
module txwDatapath
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txwStrobe_t        strb,
  input  logic [DATA_W-1:0] loadData,
  input  logic [CNT_W-1:0]  loadCount,
  output logic [BYTE_W-1:0] pushData,
  output logic              pending
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] maskedData;
  logic [CNT_W-1:0]  byteCnt;

  // zero the lanes the selected register does not carry
  for (genvar lane = 0; lane < LANES; lane++) begin : g_mask
    assign maskedData[lane*BYTE_W +: BYTE_W] =
      (CNT_W'(lane) < loadCount) ? loadData[lane*BYTE_W +: BYTE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      byteCnt  <= '0;
    end else if (strb.load) begin
      shiftReg <= maskedData;
      byteCnt  <= loadCount;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> BYTE_W;
      byteCnt  <= byteCnt - 1'b1;
    end
  end

  assign pushData = shiftReg[BYTE_W-1:0];
  assign pending  = (byteCnt != '0);

endmodule

// File: rtl/txwCtrl.sv
module txwCtrl
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             errClr,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             pending,
  output logic             wrReady,
  output logic             pushValid,
  output logic             errFlag,
  output logic [CNT_W-1:0] loadCount,
  output txwStrobe_t       strb
);

  logic [IDX_W-1:0] lastIdx;
  logic             havePrev;
  logic             accept;
  logic             badSwitch;

  assign wrReady   = !pending && !fifoFull;
  assign accept    = wrValid && wrReady;
  assign badSwitch = havePrev && (wrIdx != lastIdx) && !fifoEmpty;

  always_comb begin
    strb       = '0;
    strb.load  = accept && !badSwitch;
    strb.drop  = accept && badSwitch;
    strb.shift = pending && !fifoFull;
  end

  assign pushValid = strb.shift;
  assign loadCount = CNT_W'(bytesForIdx(int'(wrIdx), LANES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIdx  <= '0;
      havePrev <= 1'b0;
    end else if (strb.load) begin
      lastIdx  <= wrIdx;
      havePrev <= 1'b1;
    end
  end

  // a new violation wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (strb.drop) errFlag <= 1'b1;
    else if (errClr)    errFlag <= 1'b0;
  end

endmodule

// File: rtl/txWritePort.sv
module txWritePort
  import txw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              errClr,
  output logic              errFlag,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData,
  input  logic              fifoFull,
  input  logic              fifoEmpty
);

  txwStrobe_t       strb;
  logic             pending;
  logic [CNT_W-1:0] loadCount;

  txwCtrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrIdx     (wrIdx),
    .errClr    (errClr),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .pending   (pending),
    .wrReady   (wrReady),
    .pushValid (pushValid),
    .errFlag   (errFlag),
    .loadCount (loadCount),
    .strb      (strb)
  );

  txwDatapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .loadData  (wrData),
    .loadCount (loadCount),
    .pushData  (pushData),
    .pending   (pending)
  );

endmodule

// File: rtl/txWritePortChk.sv
module txWritePortChk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [IDX_W-1:0]  wrIdx,
  input logic              wrReady,
  input logic              errClr,
  input logic              errFlag,
  input logic              pushValid,
  input logic              fifoFull,
  input logic              fifoEmpty
);

  logic [IDX_W-1:0] seenIdx;
  logic             seenAny;
  logic [CNT_W-1:0] expPend;
  logic             taken;
  logic             illegal;

  assign taken   = wrValid && wrReady;
  assign illegal = taken && seenAny && (wrIdx != seenIdx) && !fifoEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenIdx <= '0;
      seenAny <= 1'b0;
      expPend <= '0;
    end else begin
      if (taken && !illegal) begin
        seenIdx <= wrIdx;
        seenAny <= 1'b1;
        expPend <= (wrIdx == '0) ? CNT_W'(LANES) : CNT_W'(wrIdx);
      end else if (pushValid) begin
        expPend <= expPend - 1'b1;
      end
    end
  end

  assert_push_not_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !fifoFull);

  assert_push_has_bytes_R5: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (expPend != '0));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !wrReady);

  assert_full_not_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !wrReady);

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> (errFlag && !pushValid));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !wrValid) |=> !errFlag);

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rstN |=> (!errFlag && !pushValid));

endmodule

bind txWritePort txWritePortChk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrValid   (wrValid),
  .wrIdx     (wrIdx),
  .wrReady   (wrReady),
  .errClr    (errClr),
  .errFlag   (errFlag),
  .pushValid (pushValid),
  .fifoFull  (fifoFull),
  .fifoEmpty (fifoEmpty)
);

// File: tb/test_txWritePort.sv
`timescale 1ns/1ps
module test_txWritePort;

  localparam int DEPTH = 8;

  typedef struct packed {
    logic        drain;
    logic        clr;
    logic [1:0]  idx;
    logic [31:0] data;
    logic [2:0]  expN;
    logic        expErr;
  } vec_t;

  // drain, clear, index, data, expected byte count, expected error flag
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 2'd1, 32'hA5A5A53C, 3'd1, 1'b0},  // R2 R10 R11 first write
    '{1'b0, 1'b0, 2'd1, 32'h9999997E, 3'd1, 1'b0},  // R8 same index, FIFO not empty
    '{1'b0, 1'b0, 2'd2, 32'h00005566, 3'd0, 1'b1},  // R7 switch while not empty
    '{1'b1, 1'b0, 2'd2, 32'hFFFF1234, 3'd2, 1'b1},  // R3 R10, R9 flag still held
    '{1'b1, 1'b1, 2'd0, 32'hDEADBEEF, 3'd4, 1'b0},  // R1 R8 switch after drain, R9 clear
    '{1'b1, 1'b0, 2'd3, 32'hFFAABBCC, 3'd3, 1'b0},  // R4 R10
    '{1'b0, 1'b0, 2'd0, 32'h01020304, 3'd0, 1'b1},  // R7 dropped
    '{1'b0, 1'b1, 2'd3, 32'h00112233, 3'd3, 1'b0}   // R8 drop kept old index, R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        wrReady;
  logic        errClr = 1'b0;
  logic        errFlag;
  logic        pushValid;
  logic [7:0]  pushData;
  logic        fifoFull;
  logic        fifoEmpty;
  logic        popEn = 1'b0;

  int fifoCount = 0;
  int logCount = 0;
  logic [7:0] logMem [256];
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  txWritePort i_txWritePort (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrData(wrData),
    .wrReady(wrReady), .errClr(errClr), .errFlag(errFlag), .pushValid(pushValid),
    .pushData(pushData), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  assign fifoFull  = (fifoCount == DEPTH);
  assign fifoEmpty = (fifoCount == 0);

  // FIFO occupancy model and push log
  always @(posedge clk) begin
    fifoCount <= fifoCount + (pushValid ? 1 : 0) - ((popEn && fifoCount > 0) ? 1 : 0);
    if (pushValid) begin
      logMem[logCount[7:0]] <= pushData;
      logCount <= logCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drainFifo();
    @(negedge clk);
    popEn = 1'b1;
    while (fifoCount != 0 || pushValid) @(negedge clk);
    popEn = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    wrValid = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin : main
    int start;
    repeat (3) @(negedge clk);
    check(errFlag == 1'b0, "R11 errFlag", errFlag, 0);
    check(pushValid == 1'b0, "R11 pushValid", pushValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(wrReady == 1'b1, "R11 wrReady", wrReady, 1);

    foreach (VECS[i]) begin
      if (VECS[i].drain) drainFifo();
      if (VECS[i].clr) pulseClr();
      start = logCount;
      writeReg(VECS[i].idx, VECS[i].data);
      repeat (6) @(negedge clk);
      check(logCount - start == int'(VECS[i].expN), $sformatf("R1-4/R7 row%0d count", i),
            logCount - start, VECS[i].expN);
      for (int k = 0; k < int'(VECS[i].expN); k++)
        check(logMem[(start + k) % 256] == VECS[i].data[8*k +: 8],
              $sformatf("R1/R2/R3/R4/R10 row%0d byte%0d", i, k),
              logMem[(start + k) % 256], VECS[i].data[8*k +: 8]);
      check(errFlag == VECS[i].expErr, $sformatf("R7/R9 row%0d errFlag", i),
            errFlag, VECS[i].expErr);
    end

    // full-FIFO stall: R5 and R6
    drainFifo();
    writeReg(2'd0, 32'h04030201);
    writeReg(2'd0, 32'h08070605);
    repeat (6) @(negedge clk);
    check(fifoFull == 1'b1, "R5 fifo filled", fifoFull, 1);
    check(wrReady == 1'b0, "R6 ready low when full", wrReady, 0);
    start = logCount;
    wrValid = 1'b1; wrIdx = 2'd0; wrData = 32'h0C0B0A09;
    repeat (4) @(negedge clk);
    check(logCount == start, "R5 no push while full", logCount - start, 0);
    popEn = 1'b1;
    @(negedge clk);
    popEn = 1'b0;
    check(wrReady == 1'b1, "R6 ready after pop", wrReady, 1);
    @(negedge clk);
    wrValid = 1'b0;
    check(wrReady == 1'b0, "R6 ready low while pending", wrReady, 0);
    repeat (4) @(negedge clk);
    check(logCount - start == 1, "R5 push stalls when full again", logCount - start, 1);
    drainFifo();
    check(logCount - start == 4, "R5 all bytes after drain", logCount - start, 4);
    for (int k = 0; k < 4; k++)
      check(logMem[(start + k) % 256] == 8'(9 + k), $sformatf("R1 R5 stalled byte%0d", k),
            logMem[(start + k) % 256], 9 + k);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule